// File: doc/BRIEF.md
# Four-Window Address Translator

This block maps a 64 MB address region onto four independent 16 MB target windows. A request carries a region-relative address, a kind (outbound memory, inbound memory or I/O) and a hit qualifier. For a memory request, the two address bits just above the 16 MB offset pick one of four windows. The high byte of the result comes from one byte of a packed 32-bit base register. Outbound and inbound memory traffic each have their own base register.

I/O requests are relocated on a 256-byte grain. A separate register holds the upper 24 target address bits in its low 24 bits. The low 8 bits of the result come from the request. The translated address leaves the block one register stage after the request, together with a valid flag.

All three base registers can be written and read over a small register port. After reset, both memory maps are contiguous, starting at target address 0.

Top module: `quad_window_xlate`

## Requirements
- R1: For memory requests, `in_addr[25:24]` selects window w. The output bits 31:24 equal byte w of the base register, with window 0 taken from bits 31:24 and window 3 from bits 7:0.
- R2: For memory requests, output bits 23:0 equal `in_addr[23:0]`.
- R3: Kind 2'b00 (outbound memory) uses the register at offset 0x34, and kind 2'b01 (inbound memory) uses the register at offset 0x2C. A write to one register does not change translations that use the other.
- R4: Kind 2'b10 (I/O) produces `{io_base[23:0], in_addr[7:0]}`, where io_base is the register at offset 0x30.
- R5: Bits 31:24 of the I/O base register always read as zero, and writes to those bits are ignored. This means an I/O base can only name a 256-byte-aligned target.
- R6: `out_valid` is high exactly one cycle after a cycle with `in_hit` high and a kind other than 2'b11. Kind 2'b11 never produces a valid output.
- R7: While `out_valid` is low, `out_addr` is zero.
- R8: After reset, the registers at 0x34 and 0x2C read 0x00010203 and the register at 0x30 reads 0.
- R9: `reg_rdata` shows, one cycle later, the register named by `reg_addr`. Any other offset reads 0, and writes to it change nothing.
- R10: A register write affects requests presented from the cycle after the write. A request in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hit | input | 1 | Request qualifier |
| in_kind | input | 2 | 00 outbound mem, 01 inbound mem, 10 I/O, 11 reserved |
| in_addr | input | 26 | Region-relative address |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 32 | Translated address |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing, including the reserved kind;
- the zero address while idle;
- pass-through of the offset bits for both memory and I/O requests;
- the zero upper byte of the I/O base readback;
- zero reads from unmapped offsets.

The byte-substitution mapping, the separation between the inbound and outbound registers, the reset map and the write-versus-request ordering are shown only by the bench's sweeps. These sweeps cover every window under contiguous and scrambled base values and a range of I/O bases, and compare against arithmetically computed addresses.

// File: rtl/qwx_pkg.sv
package qwx_pkg;
  typedef enum logic [1:0] {
    QWX_OUT_MEM = 2'b00,
    QWX_IN_MEM  = 2'b01,
    QWX_IO      = 2'b10,
    QWX_RSVD    = 2'b11
  } qwx_kind_e;

  localparam logic [7:0] QWX_OFF_IN_MEM  = 8'h2C;
  localparam logic [7:0] QWX_OFF_IO      = 8'h30;
  localparam logic [7:0] QWX_OFF_OUT_MEM = 8'h34;
endpackage

// File: rtl/qwx_regs.sv
module qwx_regs #(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 8,
  parameter int NUM_WIN = 4,
  parameter int REG_AW  = 8,
  parameter int IO_FW   = 24,
  parameter logic [REG_AW-1:0] OB_OFF = 8'h34,
  parameter logic [REG_AW-1:0] IB_OFF = 8'h2C,
  parameter logic [REG_AW-1:0] IO_OFF = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] ob_base,
  output logic [ADDR_W-1:0] ib_base,
  output logic [IO_FW-1:0]  io_field
);
  localparam int PAD_W = ADDR_W - IO_FW;

  // Contiguous map: window i gets high byte i.
  function automatic logic [ADDR_W-1:0] contig_map();
    logic [ADDR_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      v[ADDR_W-1-i*HI_W -: HI_W] = HI_W'(i);
    end
    return v;
  endfunction

  localparam logic [ADDR_W-1:0] CONTIG = contig_map();

  logic [ADDR_W-1:0] rd_mux;

  always_comb begin
    case (reg_addr)
      OB_OFF:  rd_mux = ob_base;
      IB_OFF:  rd_mux = ib_base;
      IO_OFF:  rd_mux = {{PAD_W{1'b0}}, io_field};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_base   <= CONTIG;
      ib_base   <= CONTIG;
      io_field  <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_mux;
      if (reg_wr) begin
        if (reg_addr == OB_OFF) ob_base  <= reg_wdata;
        if (reg_addr == IB_OFF) ib_base  <= reg_wdata;
        if (reg_addr == IO_OFF) io_field <= reg_wdata[IO_FW-1:0];
      end
    end
  end
endmodule

// File: rtl/qwx_win_map.sv
module qwx_win_map #(
  parameter int ADDR_W  = 32,
  parameter int HI_W    = 8,
  parameter int NUM_WIN = 4,
  parameter int SEL_W   = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SEL_W-1:0]  sel,
  output logic [HI_W-1:0]   hi
);
  logic [HI_W-1:0] lane [NUM_WIN];

  // Window 0 lives in the most significant byte.
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_lane
    assign lane[g] = base[ADDR_W-1-g*HI_W -: HI_W];
  end

  assign hi = lane[sel];
endmodule

// File: rtl/qwx_io_reloc.sv
module qwx_io_reloc #(
  parameter int ADDR_W = 32,
  parameter int LO_W   = 8,
  parameter int IO_FW  = ADDR_W - LO_W
) (
  input  logic [IO_FW-1:0]  io_field,
  input  logic [LO_W-1:0]   lo_addr,
  output logic [ADDR_W-1:0] io_addr
);
  assign io_addr = {io_field, lo_addr};
endmodule

// File: rtl/quad_window_xlate.sv
module quad_window_xlate
  import qwx_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WIN_SEL_W    = 2,
  parameter int IO_GRAN_LOG2 = 8,
  parameter int REG_AW       = 8,
  localparam int NUM_WIN     = 1 << WIN_SEL_W,
  localparam int HI_W        = ADDR_W / NUM_WIN,
  localparam int WIN_LOG2    = ADDR_W - HI_W,
  localparam int REGION_W    = WIN_LOG2 + WIN_SEL_W,
  localparam int IO_FW       = ADDR_W - IO_GRAN_LOG2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_hit,
  input  logic [1:0]          in_kind,
  input  logic [REGION_W-1:0] in_addr,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_wdata,
  output logic [ADDR_W-1:0]   reg_rdata
);
  logic [ADDR_W-1:0] ob_base, ib_base, io_addr, nxt_addr;
  logic [IO_FW-1:0]  io_field;
  logic [HI_W-1:0]   hi_ob, hi_ib;
  logic              nxt_valid;
  qwx_kind_e         kind;

  assign kind = qwx_kind_e'(in_kind);

  qwx_regs #(
    .ADDR_W(ADDR_W), .HI_W(HI_W), .NUM_WIN(NUM_WIN), .REG_AW(REG_AW),
    .IO_FW(IO_FW),
    .OB_OFF(REG_AW'(QWX_OFF_OUT_MEM)), .IB_OFF(REG_AW'(QWX_OFF_IN_MEM)),
    .IO_OFF(REG_AW'(QWX_OFF_IO))
  ) regs_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ob_base(ob_base), .ib_base(ib_base), .io_field(io_field)
  );

  qwx_win_map #(
    .ADDR_W(ADDR_W), .HI_W(HI_W), .NUM_WIN(NUM_WIN), .SEL_W(WIN_SEL_W)
  ) map_out_i (
    .base(ob_base), .sel(in_addr[REGION_W-1:WIN_LOG2]), .hi(hi_ob)
  );

  qwx_win_map #(
    .ADDR_W(ADDR_W), .HI_W(HI_W), .NUM_WIN(NUM_WIN), .SEL_W(WIN_SEL_W)
  ) map_in_i (
    .base(ib_base), .sel(in_addr[REGION_W-1:WIN_LOG2]), .hi(hi_ib)
  );

  qwx_io_reloc #(
    .ADDR_W(ADDR_W), .LO_W(IO_GRAN_LOG2), .IO_FW(IO_FW)
  ) io_i (
    .io_field(io_field), .lo_addr(in_addr[IO_GRAN_LOG2-1:0]), .io_addr(io_addr)
  );

  always_comb begin
    case (kind)
      QWX_OUT_MEM: nxt_addr = {hi_ob, in_addr[WIN_LOG2-1:0]};
      QWX_IN_MEM:  nxt_addr = {hi_ib, in_addr[WIN_LOG2-1:0]};
      QWX_IO:      nxt_addr = io_addr;
      default:     nxt_addr = '0;
    endcase
  end

  assign nxt_valid = in_hit && (kind != QWX_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= nxt_valid;
      out_addr  <= nxt_valid ? nxt_addr : '0;
    end
  end
endmodule

// File: rtl/quad_window_xlate_chk.sv
module quad_window_xlate_chk #(
  parameter int ADDR_W       = 32,
  parameter int REGION_W     = 26,
  parameter int WIN_LOG2     = 24,
  parameter int IO_GRAN_LOG2 = 8,
  parameter int REG_AW       = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_hit,
  input logic [1:0]          in_kind,
  input logic [REGION_W-1:0] in_addr,
  input logic                out_valid,
  input logic [ADDR_W-1:0]   out_addr,
  input logic [REG_AW-1:0]   reg_addr,
  input logic [ADDR_W-1:0]   reg_rdata
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R6
  a_r6_valid_timing: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid == ($past(in_hit) && ($past(in_kind) != 2'b11)));

  // R7
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_addr == '0));

  // R2
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst || !armed)
    (out_valid && ($past(in_kind) != 2'b10)) |->
      (out_addr[WIN_LOG2-1:0] == $past(in_addr[WIN_LOG2-1:0])));

  // R4
  a_r4_io_low_pass: assert property (@(posedge clk) disable iff (rst || !armed)
    (out_valid && ($past(in_kind) == 2'b10)) |->
      (out_addr[IO_GRAN_LOG2-1:0] == $past(in_addr[IO_GRAN_LOG2-1:0])));

  // R5
  a_r5_io_upper_zero: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(reg_addr) == REG_AW'(8'h30)) |->
      (reg_rdata[ADDR_W-1:ADDR_W-IO_GRAN_LOG2] == '0));

  // R9
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst || !armed)
    (($past(reg_addr) != REG_AW'(8'h30)) && ($past(reg_addr) != REG_AW'(8'h2C)) &&
     ($past(reg_addr) != REG_AW'(8'h34))) |-> (reg_rdata == '0));
endmodule

bind quad_window_xlate quad_window_xlate_chk #(
  .ADDR_W(ADDR_W), .REGION_W(REGION_W), .WIN_LOG2(WIN_LOG2),
  .IO_GRAN_LOG2(IO_GRAN_LOG2), .REG_AW(REG_AW)
) chk_i (
  .clk(clk), .rst(rst), .in_hit(in_hit), .in_kind(in_kind), .in_addr(in_addr),
  .out_valid(out_valid), .out_addr(out_addr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/quad_window_xlate_tb_top.sv
`timescale 1ns/1ps
module quad_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_hit = 1'b0;
  logic [1:0]  in_kind = 2'b00;
  logic [25:0] in_addr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  quad_window_xlate dut_i (
    .clk(clk), .rst(rst), .in_hit(in_hit), .in_kind(in_kind), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic xl(input logic hit, input logic [1:0] k, input logic [25:0] a,
                    input logic ev, input logic [31:0] ea, input string req);
    @(negedge clk);
    in_hit = hit; in_kind = k; in_addr = a;
    @(negedge clk);
    in_hit = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, {31'd0, ev});
    check({req, " addr"}, out_addr, ea);
  endtask

  function automatic logic [7:0] lane(input logic [31:0] b, input int w);
    return b[31-8*w -: 8];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] pats [3];
    logic [23:0] offs [4];
    logic [23:0] iob  [3];
    pats[0] = 32'h40414243; pats[1] = 32'hA55A0FF0; pats[2] = 32'h12FE7701;
    offs[0] = 24'h000000;   offs[1] = 24'hFFFFFF;   offs[2] = 24'h123456; offs[3] = 24'h800001;
    iob[0]  = 24'hFFFFFC;   iob[1]  = 24'h000001;   iob[2]  = 24'hABCDEF;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 reset", {31'd0, out_valid}, 32'd0);
    check("R7 reset addr", out_addr, 32'd0);
    rd(8'h34, 32'h00010203, "R8 outbound reset");
    rd(8'h2C, 32'h00010203, "R8 inbound reset");
    rd(8'h30, 32'h00000000, "R8 io reset");
    // Reset map is identity-style: window w -> high byte w
    for (int w = 0; w < 4; w++)
      xl(1'b1, 2'b00, {w[1:0], 24'h00ABCD}, 1'b1, {w[7:0], 24'h00ABCD}, "R8 identity map");

    // R9 unmapped offsets
    rd(8'h00, 32'h0, "R9 unmapped read");
    wr(8'h38, 32'hDEADBEEF);
    rd(8'h38, 32'h0, "R9 unmapped after write");
    rd(8'h34, 32'h00010203, "R9 outbound untouched");
    rd(8'h2C, 32'h00010203, "R9 inbound untouched");
    rd(8'h30, 32'h00000000, "R9 io untouched");

    // R1 R2 R3 sweep
    for (int p = 0; p < 3; p++) begin
      wr(8'h34, pats[p]);
      wr(8'h2C, ~pats[p]);
      rd(8'h34, pats[p], "R9 outbound readback");
      rd(8'h2C, ~pats[p], "R3 inbound readback");
      for (int w = 0; w < 4; w++) begin
        for (int o = 0; o < 4; o++) begin
          xl(1'b1, 2'b00, {w[1:0], offs[o]}, 1'b1, {lane(pats[p], w), offs[o]}, "R1 R2 outbound");
          xl(1'b1, 2'b01, {w[1:0], offs[o]}, 1'b1, {lane(~pats[p], w), offs[o]}, "R3 inbound");
        end
      end
    end

    // R5 upper byte of I/O base
    wr(8'h30, 32'hFFFFFFFF);
    rd(8'h30, 32'h00FFFFFF, "R5 io upper byte");

    // R4 I/O relocation sweep
    for (int b = 0; b < 3; b++) begin
      wr(8'h30, {8'h5A, iob[b]});
      rd(8'h30, {8'h00, iob[b]}, "R5 io readback");
      for (int o = 0; o < 256; o += 17)
        xl(1'b1, 2'b10, {2'b11, 16'hC3C3, o[7:0]}, 1'b1, {iob[b], o[7:0]}, "R4 io");
      xl(1'b1, 2'b10, 26'h0FFFFFF, 1'b1, {iob[b], 8'hFF}, "R4 io top");
    end

    // R6 R7 no request / reserved kind
    xl(1'b0, 2'b00, 26'h1234567, 1'b0, 32'h0, "R6 R7 no hit");
    xl(1'b1, 2'b11, 26'h2345678, 1'b0, 32'h0, "R6 R7 reserved kind");

    // R10 write and request in the same cycle
    wr(8'h34, 32'h11223344);
    @(negedge clk);
    reg_addr = 8'h34; reg_wdata = 32'h99887766; reg_wr = 1'b1;
    in_hit = 1'b1; in_kind = 2'b00; in_addr = {2'b10, 24'h000042};
    @(negedge clk);
    reg_wr = 1'b0; in_hit = 1'b0;
    check("R10 same-cycle uses old", out_addr, 32'h33000042);
    xl(1'b1, 2'b00, {2'b10, 24'h000042}, 1'b1, 32'h77000042, "R10 next uses new");
    xl(1'b1, 2'b01, {2'b10, 24'h000042}, 1'b1, {lane(~pats[2], 2), 24'h000042}, "R3 inbound isolated");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule